// File: doc/BRIEF.md
# Clear-on-read interrupt cause register

This block gathers the interrupt causes of an embedded microcontroller into one 8-bit register. The causes are four external request lines, a receive event (a packet number queued for the receive side), a transmit event (a packet sent), a drained transmit queue among sixteen, and a rising status bit from a DMA controller. Each cause sets its own bit, and the bit stays set until firmware reads the register.

The register has one address. A read returns the bits that are pending, and the clock edge that ends the read clears all of them at once. Firmware therefore has to service every cause it sees in a single read. A cause that arrives in the same cycle as the clearing read is kept for the next read.

The transmit-queue bit and the DMA bit are both edge-triggered. Each compares its inputs with a registered copy from the previous cycle, and that copy resets to zero. A single request output, the OR of all eight bits, goes to the CPU.

Top module: `evt_cause_reg`

## Requirements
- R1: After reset all eight bits are 0, a read at the register address returns 0x00, and `irq_o` is low.
- R2: The bit positions, from bit 7 down to bit 0, are: queue drained, receive queued, transmit sent, DMA edge, external request 3, 2, 1, 0.
- R3: A read with `cpu_rd` high and `cpu_addr` equal to 0x7F00 shows the pending bits on `cpu_rdata` in that cycle. The clock edge that ends the read clears every bit. A read at any other address returns 0x00 and clears nothing.
- R4: A bit sets at the clock edge where its cause is sampled. It then holds until a clearing read.
- R5: A cause sampled in the same cycle as a clearing read leaves its bit set after that read.
- R6: Each `ext_irq` line sets its bit at every edge where the line is sampled high, so a line held high sets its bit again after a read.
- R7: A high `rx_queued` sets bit 6, and a high `tx_sent` sets bit 5.
- R8: Bit 7 sets when any of the 16 `txq_empty` flags goes from 0 to 1 while its `txq_enable` bit is 1. A rise on a queue whose enable bit is 0 has no effect, and a flag held high does not set the bit again after a read.
- R9: Bit 4 sets when any `dma_status` bit goes from 0 to 1 while its `dma_select` bit is 1. Deselected channels and steady-high bits have no effect. A new rise after a read sets the bit again.
- R10: `irq_o` is high exactly when any bit is set. It goes low in the cycle after a clearing read when no cause arrives in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU read address |
| cpu_rdata | output | 8 | Read data: the pending bits on a hit, otherwise 0 |
| ext_irq | input | 4 | External request lines, active high |
| rx_queued | input | 1 | Receive packet number queued |
| tx_sent | input | 1 | Packet transmitted |
| txq_empty | input | 16 | Per-queue empty flags |
| txq_enable | input | 16 | Per-queue enable |
| dma_status | input | 8 | DMA per-channel status bits |
| dma_select | input | 8 | DMA channel select, 1 = channel counts |
| irq_o | output | 1 | Combined interrupt request to the CPU |

## Verification
Directed sequences drive one cause at a time and read it back, which separates the bit positions from each other. The same sequences hold a level high across a read, which shows that edge-triggered bits stay cleared while level-sensitive external lines set again. Causes are also placed in the same cycle as a clearing read, which separates "cleared then set" from "set then cleared". Seeded random traffic runs against a bench model and mixes sparse causes, toggling queue enables and DMA selects, and reads at both the register address and other addresses, so any lost or spurious bit shows up on the read data or on `irq_o`.

// File: rtl/evt_cause_pkg.sv
package evt_cause_pkg;

  localparam int unsigned CAUSE_W = 8;
  localparam int unsigned EXT_W   = 4;

  // Field order is what firmware decodes: MSB first.
  typedef struct packed {
    logic             txq_drained;  // bit 7
    logic             rx_queued;    // bit 6
    logic             tx_sent;      // bit 5
    logic             dma_edge;     // bit 4
    logic [EXT_W-1:0] ext;          // bits 3..0
  } cause_evt_t;

  typedef logic [CAUSE_W-1:0] cause_vec_t;

  // Next value of a sticky vector: clear first, then new causes win.
  function automatic cause_vec_t sticky_next(input cause_vec_t cur,
                                             input logic       clr,
                                             input cause_vec_t set);
    return (clr ? '0 : cur) | set;
  endfunction

endpackage

// File: rtl/evt_rise_det.sv
module evt_rise_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  output logic [W-1:0] rise_vec,
  output logic         rise_any
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_vec[i] = lvl[i] & ~prev_q[i] & en[i];
  end

  assign rise_any = |rise_vec;

  AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((rise_vec & $past(rise_vec)) == '0)); // R9

endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank
  import evt_cause_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_vec_t set,
  input  logic       clr,
  output cause_vec_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sticky_next(q, clr, set);
  end

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == $past(set))); // R3
  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q))); // R4
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R5

endmodule

// File: rtl/evt_rd_port.sv
module evt_rd_port
  import evt_cause_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 16'h7F00
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  cause_vec_t        cur,
  output cause_vec_t        rdata,
  output logic              clr
);

  logic hit;

  assign hit   = (addr == REG_ADDR);
  assign clr   = rd & hit;
  assign rdata = clr ? cur : '0;

endmodule

// File: rtl/evt_cause_reg.sv
module evt_cause_reg
  import evt_cause_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h7F00,
  parameter int unsigned       N_TXQ    = 16,
  parameter int unsigned       N_DMA    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [7:0]        cpu_rdata,
  input  logic [3:0]        ext_irq,
  input  logic              rx_queued,
  input  logic              tx_sent,
  input  logic [N_TXQ-1:0]  txq_empty,
  input  logic [N_TXQ-1:0]  txq_enable,
  input  logic [N_DMA-1:0]  dma_status,
  input  logic [N_DMA-1:0]  dma_select,
  output logic              irq_o
);

  logic [N_TXQ-1:0] txq_rise;
  logic             txq_rise_any;
  logic [N_DMA-1:0] dma_rise;
  logic             dma_rise_any;
  cause_evt_t       evt;
  cause_vec_t       evt_vec;
  cause_vec_t       pend_q;
  logic             rd_clr;

  evt_rise_det #(.W(N_TXQ)) u_txq_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (txq_empty),
    .en       (txq_enable),
    .rise_vec (txq_rise),
    .rise_any (txq_rise_any)
  );

  evt_rise_det #(.W(N_DMA)) u_dma_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (dma_status),
    .en       (dma_select),
    .rise_vec (dma_rise),
    .rise_any (dma_rise_any)
  );

  always_comb begin
    evt             = '0;
    evt.txq_drained = txq_rise_any;
    evt.rx_queued   = rx_queued;
    evt.tx_sent     = tx_sent;
    evt.dma_edge    = dma_rise_any;
    evt.ext         = ext_irq;
  end

  assign evt_vec = cause_vec_t'(evt);

  evt_rd_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
    .rd    (cpu_rd),
    .addr  (cpu_addr),
    .cur   (pend_q),
    .rdata (cpu_rdata),
    .clr   (rd_clr)
  );

  evt_sticky_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt_vec),
    .clr   (rd_clr),
    .q     (pend_q)
  );

  assign irq_o = |pend_q;

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt_vec == '0) |=> !irq_o); // R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> irq_o); // R4
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr != REG_ADDR && irq_o) |=> irq_o); // R3
  AST_TXQ_TO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    txq_rise_any |=> pend_q[7]); // R8
  AST_DMA_TO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rise_any |=> pend_q[4]); // R9

endmodule

// File: tb/evt_cause_reg_tb.sv
`timescale 1ns/1ps
module evt_cause_reg_tb;

  localparam logic [15:0] RADDR = 16'h7F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_rdata;
  logic [3:0]  ext_irq = '0;
  logic        rx_queued = 1'b0;
  logic        tx_sent = 1'b0;
  logic [15:0] txq_empty = '0;
  logic [15:0] txq_enable = '0;
  logic [7:0]  dma_status = '0;
  logic [7:0]  dma_select = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_q = '0;
  logic [15:0] m_txe_prev = '0;
  logic [7:0]  m_dma_prev = '0;

  always #2.5 clk = ~clk;

  evt_cause_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .ext_irq(ext_irq), .rx_queued(rx_queued),
    .tx_sent(tx_sent), .txq_empty(txq_empty), .txq_enable(txq_enable),
    .dma_status(dma_status), .dma_select(dma_select), .irq_o(irq_o)
  );

  function automatic logic [7:0] cause_of(
      input logic [15:0] te, input logic [15:0] tp, input logic [15:0] ten,
      input logic [7:0] ds, input logic [7:0] dp, input logic [7:0] dsel,
      input logic rx, input logic tx, input logic [3:0] ex);
    logic [7:0] v;
    v[7]   = ((te & ~tp & ten) != 16'h0);
    v[6]   = rx;
    v[5]   = tx;
    v[4]   = ((ds & ~dp & dsel) != 8'h0);
    v[3:0] = ex;
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge with inputs set; checks, advances model one clock.
  task automatic step();
    logic hit;
    logic [7:0] ev;
    #1;
    hit = cpu_rd && (cpu_addr == RADDR);
    chk("R3 rdata", cpu_rdata, hit ? m_q : 8'h00);
    chk("R10 irq", {7'b0, irq_o}, {7'b0, (m_q != 8'h0)});
    ev = cause_of(txq_empty, m_txe_prev, txq_enable, dma_status, m_dma_prev,
                  dma_select, rx_queued, tx_sent, ext_irq);
    m_q = (hit ? 8'h00 : m_q) | ev;
    m_txe_prev = txq_empty;
    m_dma_prev = dma_status;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_rd = 1'b0; rx_queued = 1'b0; tx_sent = 1'b0; ext_irq = '0;
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    cpu_rd = 1'b1; cpu_addr = RADDR;
    #1 chk(req, cpu_rdata, exp);
    step();
    cpu_rd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    read_expect("R1 reset value", 8'h00);

    // R2 / R6 single external line
    ext_irq = 4'b0100; step(); quiet();
    read_expect("R2 R6 ext line 2", 8'h04);
    // R6 held high sets again after read
    ext_irq = 4'b0001; step();
    read_expect("R6 held line first read", 8'h01);
    read_expect("R6 held line re-set", 8'h01);
    quiet(); step();
    read_expect("R6 line dropped", 8'h01);
    read_expect("R3 cleared", 8'h00);

    // R7 receive and transmit
    rx_queued = 1'b1; step(); quiet();
    read_expect("R7 R2 rx bit6", 8'h40);
    tx_sent = 1'b1; step(); quiet();
    read_expect("R7 R2 tx bit5", 8'h20);

    // R5 cause coincides with clearing read
    tx_sent = 1'b1; step(); quiet();
    rx_queued = 1'b1;
    read_expect("R5 read shows old", 8'h20);
    rx_queued = 1'b0;
    read_expect("R5 coincident cause kept", 8'h40);

    // R3 read at another address returns zero and keeps bits
    tx_sent = 1'b1; step(); quiet();
    cpu_rd = 1'b1; cpu_addr = 16'h7F01;
    #1 chk("R3 miss returns zero", cpu_rdata, 8'h00);
    step(); cpu_rd = 1'b0;
    read_expect("R3 miss kept bits", 8'h20);

    // R10 irq drops after clear
    chk("R10 irq low after clear", {7'b0, irq_o}, 8'h00);

    // R8 queue drained
    txq_enable = 16'h0200; txq_empty[9] = 1'b1; step();
    read_expect("R8 enabled queue rise", 8'h80);
    read_expect("R8 held flag no re-set", 8'h00);
    txq_empty[3] = 1'b1; step();
    read_expect("R8 disabled queue ignored", 8'h00);
    txq_empty = '0; step();
    txq_enable = 16'h8000; txq_empty[15] = 1'b1; step();
    read_expect("R8 last queue", 8'h80);

    // R9 DMA edge
    dma_select = 8'h08; dma_status[3] = 1'b1; step();
    read_expect("R9 selected rise", 8'h10);
    read_expect("R9 steady high ignored", 8'h00);
    dma_status[6] = 1'b1; step();
    read_expect("R9 deselected ignored", 8'h00);
    dma_status[3] = 1'b0; step();
    dma_status[3] = 1'b1; step();
    read_expect("R9 new rise re-sets", 8'h10);
    txq_empty = '0; dma_status = '0; step();

    // Random traffic against the model (R4 and all others)
    for (int n = 0; n < 4000; n++) begin
      ext_irq   = ($urandom % 12 == 0) ? 4'($urandom) : 4'h0;
      rx_queued = ($urandom % 9 == 0);
      tx_sent   = ($urandom % 9 == 0);
      if ($urandom % 20 == 0) txq_enable = 16'($urandom);
      if ($urandom % 6 == 0)  txq_empty[$urandom % 16] ^= 1'b1;
      if ($urandom % 20 == 0) dma_select = 8'($urandom);
      if ($urandom % 5 == 0)  dma_status[$urandom % 8] ^= 1'b1;
      cpu_rd   = ($urandom % 4 == 0);
      cpu_addr = ($urandom % 4 == 0) ? 16'($urandom) : RADDR;
      step();
    end
    quiet(); step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule